// File: doc/BRIEF.md
# GPIO Port Bank with Indirect Pin Configuration

This block is a 29-pin general-purpose I/O unit. The pins are grouped into four byte-wide ports; pin n sits on port n/8 at bit n%8. A host reaches the port data through a 16-byte register window. Every port has an output-data byte and an input-data byte, and the first two ports also have an event-enable byte and an event-status byte. Inputs pass through a two-flop synchroniser before they can be read or used to detect events.

The electrical setup of each pin is not in the window. The host first writes a selector byte that names a pin as (port << 4) | bit. It then reads or writes a 3-bit configuration for that pin: output enable, push-pull versus open-drain, and pull-up. The block drives per-pin output-enable, output-value and pull-up signals towards the pads and samples the pad inputs. The pads themselves are outside the block.

Top module: `gpio_portbank`

## Requirements
- R1: Pin n maps to port n/8, bit n%8, in the window bytes, in the selector encoding and in the per-pin output vectors.
- R2: Output-data bytes sit at window offsets 0x0, 0x4, 0x8 and 0xA for ports 0 to 3. A write stores the byte and a read returns it. Bits for pins 29 to 31 read as 0.
- R3: Input-data bytes sit at offsets 0x1, 0x5, 0x9 and 0xB. They return pin_in after a two-flop synchroniser, so a change shows after the second rising clock edge. Bits for pins 29 to 31 read as 0.
- R4: Event-enable bytes sit at 0x2 (port 0) and 0x6 (port 1), and event-status bytes sit at 0x3 and 0x7. A status bit sets on a rising edge of its synchronised input while its enable bit is 1. A falling edge, or a rise on a disabled pin, leaves it unchanged.
- R5: Writing 1 to an event-status bit clears it and writing 0 leaves it unchanged. If a clear and a new rising edge fall in the same cycle, the bit stays set.
- R6: A selector write takes (port << 4) | bit from cfg_wdata bits [5:4] and [2:0]. Configuration reads return {5'b0, pull-up, push-pull, output-enable} of the selected pin, and configuration writes update that pin only.
- R7: If the selector names a pin numbered 29 or above, configuration writes are ignored and configuration reads return 0.
- R8: When configuration bit 0 (output enable) is 0, pin_oe for that pin is 0 (tristate), whatever the output data.
- R9: With output enable and bit 1 (push-pull) set, pin_oe is 1 and pin_out equals the pin's output-data bit.
- R10: In open-drain mode (bit 1 clear, output enable set), the pin is driven low (pin_oe 1, pin_out 0) when its data bit is 0, and released (pin_oe 0) when its data bit is 1.
- R11: Configuration bit 2 drives pin_pu for that pin.
- R12: After reset all data, enable, status, selector and configuration state is 0, so pin_oe, pin_out and pin_pu are all 0.
- R13: Window offsets 0xC to 0xF read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| win_wr | input | 1 | Window write strobe |
| win_addr | input | 4 | Window byte offset |
| win_wdata | input | 8 | Window write data |
| win_rdata | output | 8 | Window read data (combinational from win_addr) |
| sel_wr | input | 1 | Pin selector write strobe (data on cfg_wdata) |
| cfg_wr | input | 1 | Selected-pin configuration write strobe |
| cfg_wdata | input | 8 | Selector or configuration write data |
| cfg_rdata | output | 8 | Configuration of the selected pin |
| pin_in | input | 29 | Sampled pad inputs |
| pin_oe | output | 29 | Per-pin output enable |
| pin_out | output | 29 | Per-pin driven value |
| pin_pu | output | 29 | Per-pin pull-up enable |

## Verification
Most of the state in this block can be seen directly. A corrupted configuration bit shows on pin_oe, pin_out or pin_pu in the cycle after the write that caused it. A wrong selector decode shows as the wrong pin moving, or as a write to an out-of-range pin landing somewhere. Synchroniser faults show as input data appearing one edge too early or too late. Event faults are the slowest to surface: they show only when the host reads the status byte, so the bench reads status a few cycles after each edge and again after each clear.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
   localparam int BYTE_W     = 8;
   localparam int NUM_PORTS  = 4;
   localparam int PAD_W      = NUM_PORTS * BYTE_W;
   localparam int CFG_OE_BIT = 0;
   localparam int CFG_PP_BIT = 1;
   localparam int CFG_PU_BIT = 2;

   typedef enum logic [2:0] {RK_NONE, RK_DOUT, RK_DIN, RK_EVEN, RK_EVST} reg_kind_e;

   typedef struct packed {
      reg_kind_e  kind;
      logic [1:0] port;
   } reg_hit_t;

   // Offsets below 8: two ports with four bytes each. 8..B: two ports with data bytes only.
   function automatic reg_hit_t decode_win(input logic [3:0] a);
      reg_hit_t h;
      h.kind = RK_NONE;
      h.port = 2'd0;
      if (!a[3]) begin
         h.port = {1'b0, a[2]};
         case (a[1:0])
            2'd0:    h.kind = RK_DOUT;
            2'd1:    h.kind = RK_DIN;
            2'd2:    h.kind = RK_EVEN;
            default: h.kind = RK_EVST;
         endcase
      end else if (!a[2]) begin
         h.port = {1'b1, a[1]};
         h.kind = a[0] ? RK_DIN : RK_DOUT;
      end
      return h;
   endfunction
endpackage

// File: rtl/gpb_insync.sv
module gpb_insync #(
   parameter int NUM_PINS = 29,
   parameter int STAGES   = 2
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] sync_out,
   output logic [NUM_PINS-1:0] rise_out
);
   logic [STAGES-1:0][NUM_PINS-1:0] chain;
   logic [NUM_PINS-1:0]             last_q;

   generate
      if (STAGES < 1) begin : g_bad
         $error("gpb_insync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= pin_in;
         end
      end else begin : g_multi
         always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], pin_in};
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) last_q <= '0;
      else     last_q <= sync_out;
   end

   assign sync_out = chain[STAGES-1];
   assign rise_out = sync_out & ~last_q;

   AST_FIRST_STAGE: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> chain[0] == $past(pin_in)); // R3
   AST_RISE_IS_HIGH: assert property (@(posedge clk) disable iff (rst)
      (rise_out & ~sync_out) == '0 && (rise_out & $past(sync_out)) == '0); // R4
endmodule

// File: rtl/gpb_pincfg.sv
module gpb_pincfg
   import gpb_pkg::*;
#(
   parameter int NUM_PINS = 29
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                sel_wr,
   input  logic                cfg_wr,
   input  logic [7:0]          wdata,
   output logic [7:0]          rdata,
   output logic [NUM_PINS-1:0] oe_cfg,
   output logic [NUM_PINS-1:0] pp_cfg,
   output logic [NUM_PINS-1:0] pu_cfg
);
   localparam int IDX_W = $clog2(PAD_W);

   logic [1:0]       sel_port;
   logic [2:0]       sel_bit;
   logic [IDX_W-1:0] sel_idx;
   logic             sel_valid;

   assign sel_idx   = IDX_W'({sel_port, sel_bit});
   assign sel_valid = 32'(sel_idx) < NUM_PINS;

   always_ff @(posedge clk) begin
      if (rst) begin
         sel_port <= '0;
         sel_bit  <= '0;
         oe_cfg   <= '0;
         pp_cfg   <= '0;
         pu_cfg   <= '0;
      end else begin
         if (sel_wr) begin
            sel_port <= wdata[5:4];
            sel_bit  <= wdata[2:0];
         end
         if (cfg_wr && sel_valid) begin
            for (int i = 0; i < NUM_PINS; i++) begin
               if (IDX_W'(i) == sel_idx) begin
                  oe_cfg[i] <= wdata[CFG_OE_BIT];
                  pp_cfg[i] <= wdata[CFG_PP_BIT];
                  pu_cfg[i] <= wdata[CFG_PU_BIT];
               end
            end
         end
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_PINS; i++) begin
         if (IDX_W'(i) == sel_idx) begin
            rdata[CFG_OE_BIT] = oe_cfg[i];
            rdata[CFG_PP_BIT] = pp_cfg[i];
            rdata[CFG_PU_BIT] = pu_cfg[i];
         end
      end
   end

   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
      !cfg_wr |=> $stable({oe_cfg, pp_cfg, pu_cfg})); // R6
   AST_BAD_SEL_IGNORED: assert property (@(posedge clk) disable iff (rst)
      cfg_wr && !sel_valid |=> $stable({oe_cfg, pp_cfg, pu_cfg})); // R7
endmodule

// File: rtl/gpb_portregs.sv
module gpb_portregs
   import gpb_pkg::*;
#(
   parameter int NUM_PINS  = 29,
   parameter int EVT_PORTS = 2
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                win_wr,
   input  logic [3:0]          win_addr,
   input  logic [7:0]          win_wdata,
   output logic [7:0]          win_rdata,
   input  logic [NUM_PINS-1:0] sync_in,
   input  logic [NUM_PINS-1:0] rise_in,
   output logic [NUM_PINS-1:0] dout
);
   localparam int EVW = EVT_PORTS * BYTE_W;

   generate
      if (EVW > NUM_PINS || EVT_PORTS > 2) begin : g_bad
         $error("gpb_portregs: event ports exceed pins or window map");
      end
   endgenerate

   reg_hit_t         hit;
   logic [EVW-1:0]   ev_en, ev_st;
   logic [PAD_W-1:0] dout_pad, din_pad;

   assign hit      = decode_win(win_addr);
   assign dout_pad = PAD_W'(dout);
   assign din_pad  = PAD_W'(sync_in);

   always_ff @(posedge clk) begin
      if (rst) begin
         dout  <= '0;
         ev_en <= '0;
         ev_st <= '0;
      end else begin
         for (int i = 0; i < NUM_PINS; i++) begin
            if (win_wr && hit.kind == RK_DOUT && 2'(i / BYTE_W) == hit.port)
               dout[i] <= win_wdata[i % BYTE_W];
         end
         for (int i = 0; i < EVW; i++) begin
            if (win_wr && hit.kind == RK_EVEN && 2'(i / BYTE_W) == hit.port)
               ev_en[i] <= win_wdata[i % BYTE_W];
            if (win_wr && hit.kind == RK_EVST && 2'(i / BYTE_W) == hit.port &&
                win_wdata[i % BYTE_W])
               ev_st[i] <= 1'b0;
            if (rise_in[i] && ev_en[i])
               ev_st[i] <= 1'b1;   // set wins over clear
         end
      end
   end

   always_comb begin
      unique case (hit.kind)
         RK_DOUT: win_rdata = dout_pad[hit.port*BYTE_W +: BYTE_W];
         RK_DIN:  win_rdata = din_pad[hit.port*BYTE_W +: BYTE_W];
         RK_EVEN: win_rdata = ev_en[hit.port[0]*BYTE_W +: BYTE_W];
         RK_EVST: win_rdata = ev_st[hit.port[0]*BYTE_W +: BYTE_W];
         default: win_rdata = '0;
      endcase
   end

   AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (rst)
      !win_wr |=> $stable(dout)); // R2
   AST_EVT_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
      (ev_st & ~$past(ev_st) & ~$past(ev_en)) == '0); // R4
endmodule

// File: rtl/gpio_portbank.sv
module gpio_portbank
   import gpb_pkg::*;
#(
   parameter int NUM_PINS    = 29,
   parameter int SYNC_STAGES = 2,
   parameter int EVT_PORTS   = 2
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                win_wr,
   input  logic [3:0]          win_addr,
   input  logic [7:0]          win_wdata,
   output logic [7:0]          win_rdata,
   input  logic                sel_wr,
   input  logic                cfg_wr,
   input  logic [7:0]          cfg_wdata,
   output logic [7:0]          cfg_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_pu
);
   generate
      if (NUM_PINS > PAD_W || NUM_PINS <= 3 * BYTE_W) begin : g_bad
         $error("gpio_portbank: NUM_PINS must fill four byte ports");
      end
   endgenerate

   logic [NUM_PINS-1:0] sync_v, rise_v, dout_v;
   logic [NUM_PINS-1:0] oe_v, pp_v, pu_v;

   gpb_insync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .pin_in(pin_in),
      .sync_out(sync_v), .rise_out(rise_v));

   gpb_portregs #(.NUM_PINS(NUM_PINS), .EVT_PORTS(EVT_PORTS)) u_regs (
      .clk(clk), .rst(rst), .win_wr(win_wr), .win_addr(win_addr),
      .win_wdata(win_wdata), .win_rdata(win_rdata),
      .sync_in(sync_v), .rise_in(rise_v), .dout(dout_v));

   gpb_pincfg #(.NUM_PINS(NUM_PINS)) u_cfg (
      .clk(clk), .rst(rst), .sel_wr(sel_wr), .cfg_wr(cfg_wr),
      .wdata(cfg_wdata), .rdata(cfg_rdata),
      .oe_cfg(oe_v), .pp_cfg(pp_v), .pu_cfg(pu_v));

   // Open-drain pins only ever drive low; push-pull pins drive the data bit.
   assign pin_oe  = oe_v & (pp_v | ~dout_v);
   assign pin_out = dout_v & pp_v;
   assign pin_pu  = pu_v;

   AST_RESET_QUIET: assert property (@(posedge clk)
      rst |=> pin_oe == '0 && pin_out == '0 && pin_pu == '0); // R12
   AST_DRIVE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
      !win_wr && !cfg_wr |=> $stable(pin_oe) && $stable(pin_out)); // R8
endmodule

// File: tb/gpio_portbank_test.sv
`timescale 1ns/1ps
module gpio_portbank_test;
   localparam int NP = 29;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          win_wr = 1'b0;
   logic [3:0]    win_addr = '0;
   logic [7:0]    win_wdata = '0;
   logic [7:0]    win_rdata;
   logic          sel_wr = 1'b0;
   logic          cfg_wr = 1'b0;
   logic [7:0]    cfg_wdata = '0;
   logic [7:0]    cfg_rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_oe, pin_out, pin_pu;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      int          src;
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t sb[$];

   always #2 clk = ~clk;

   gpio_portbank uut (
      .clk(clk), .rst(rst), .win_wr(win_wr), .win_addr(win_addr),
      .win_wdata(win_wdata), .win_rdata(win_rdata), .sel_wr(sel_wr),
      .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu));

   // Monitor: pops one expectation per cycle, samples at the falling edge.
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it = sb.pop_front();
         case (it.src)
            0: act = 32'(win_rdata);
            1: act = 32'(cfg_rdata);
            2: act = 32'(pin_oe);
            3: act = 32'(pin_out);
            default: act = 32'(pin_pu);
         endcase
         checks++;
         if (act !== it.exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
         end
      end
   end

   task automatic expect_sig(int src, logic [31:0] v, string tag);
      @(posedge clk); #1;
      sb.push_back('{src, v, tag});
   endtask

   task automatic rd_win(logic [3:0] a, logic [7:0] v, string tag);
      @(posedge clk); #1;
      win_addr = a;
      sb.push_back('{0, 32'(v), tag});
   endtask

   task automatic wr_win(logic [3:0] a, logic [7:0] d);
      @(posedge clk); #1;
      win_wr = 1'b1; win_addr = a; win_wdata = d;
      @(posedge clk); #1;
      win_wr = 1'b0;
   endtask

   task automatic wr_sel(logic [7:0] d);
      @(posedge clk); #1;
      sel_wr = 1'b1; cfg_wdata = d;
      @(posedge clk); #1;
      sel_wr = 1'b0;
   endtask

   task automatic wr_cfg(logic [7:0] d);
      @(posedge clk); #1;
      cfg_wr = 1'b1; cfg_wdata = d;
      @(posedge clk); #1;
      cfg_wr = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(posedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      idle(3);
      @(posedge clk); #1 rst = 1'b0;

      // R12 reset state
      expect_sig(2, 0, "R12 pin_oe after reset");
      expect_sig(3, 0, "R12 pin_out after reset");
      expect_sig(4, 0, "R12 pin_pu after reset");
      expect_sig(1, 0, "R12 cfg after reset");
      rd_win(4'h0, 8'h00, "R12 dout0 after reset");

      // R2 data-out registers
      wr_win(4'h0, 8'hA5); rd_win(4'h0, 8'hA5, "R2 dout port0");
      wr_win(4'h8, 8'h3C); rd_win(4'h8, 8'h3C, "R2 dout port2");
      wr_win(4'hA, 8'hFF); rd_win(4'hA, 8'h1F, "R2 dout port3 upper bits 0");
      expect_sig(2, 0, "R8 no drive while unconfigured");

      // R3 synchroniser latency and data-in map
      @(posedge clk); #1;
      pin_in = 29'h15A3C65A; win_addr = 4'h1;
      sb.push_back('{0, 32'h00, "R3 din before edge"});
      @(posedge clk); #1 sb.push_back('{0, 32'h00, "R3 din after one edge"});
      @(posedge clk); #1 sb.push_back('{0, 32'h5A, "R3 din after two edges"});
      rd_win(4'h5, 8'hC6, "R3 R1 din port1");
      rd_win(4'h9, 8'hA3, "R3 din port2");
      rd_win(4'hB, 8'h15, "R3 din port3");
      @(posedge clk); #1 pin_in = '0;
      idle(4);

      // R4 R5 events
      wr_win(4'h2, 8'h01);
      wr_win(4'h6, 8'h80);
      rd_win(4'h2, 8'h01, "R4 enable readback");
      rd_win(4'h3, 8'h00, "R4 no status from falling edge");
      @(posedge clk); #1 pin_in = 29'h0000_8003;
      idle(5);
      rd_win(4'h3, 8'h01, "R4 port0 status only enabled pin");
      rd_win(4'h7, 8'h80, "R4 port1 status pin15");
      @(posedge clk); #1 pin_in = 29'h0000_8002;
      idle(5);
      rd_win(4'h3, 8'h01, "R4 falling edge keeps status");
      wr_win(4'h3, 8'h01); rd_win(4'h3, 8'h00, "R5 write one clears");
      wr_win(4'h7, 8'h00); rd_win(4'h7, 8'h80, "R5 write zero keeps");
      wr_win(4'h7, 8'h80); rd_win(4'h7, 8'h00, "R5 write one clears port1");
      @(posedge clk); #1 pin_in = '0;
      idle(5);
      rd_win(4'h7, 8'h00, "R4 falling edge sets nothing");

      // R6 R9 R10 R11 configuration
      wr_win(4'h4, 8'h04);
      wr_sel(8'h12); wr_cfg(8'h03);
      expect_sig(1, 32'h03, "R6 cfg readback pin10");
      expect_sig(2, 32'h400, "R9 push-pull oe pin10");
      expect_sig(3, 32'h400, "R9 R1 push-pull value pin10");
      wr_cfg(8'h05);
      expect_sig(2, 32'h0, "R10 open-drain released on 1");
      expect_sig(3, 32'h0, "R10 open-drain value");
      expect_sig(4, 32'h400, "R11 pull-up pin10");
      wr_win(4'h4, 8'h00);
      expect_sig(2, 32'h400, "R10 open-drain drives low on 0");
      expect_sig(3, 32'h0, "R10 open-drain low value");
      wr_sel(8'h34); wr_cfg(8'h03);
      expect_sig(2, 32'h1000_0400, "R1 pin28 selected by 0x34");
      expect_sig(3, 32'h1000_0000, "R1 R9 pin28 value");
      wr_sel(8'h12);
      expect_sig(1, 32'h05, "R6 reselect pin10");
      wr_cfg(8'h04);
      expect_sig(2, 32'h1000_0000, "R8 oe clear tristates pin10");
      expect_sig(4, 32'h400, "R11 pull-up kept");

      // R7 out-of-range selector
      wr_sel(8'h35);
      expect_sig(1, 32'h0, "R7 invalid pin reads 0");
      wr_cfg(8'h07);
      expect_sig(2, 32'h1000_0000, "R7 invalid write no oe change");
      expect_sig(4, 32'h400, "R7 invalid write no pu change");
      wr_sel(8'h34);
      expect_sig(1, 32'h03, "R7 pin28 unchanged");

      // R13 unmapped offsets
      wr_win(4'hC, 8'hFF);
      rd_win(4'hC, 8'h00, "R13 offset C reads 0");
      rd_win(4'hF, 8'h00, "R13 offset F reads 0");
      rd_win(4'hA, 8'h1F, "R13 port3 data untouched");
      expect_sig(2, 32'h1000_0000, "R13 pins untouched");

      // R12 second reset
      @(posedge clk); #1 rst = 1'b1;
      @(posedge clk); #1 rst = 1'b0;
      expect_sig(2, 0, "R12 oe after second reset");
      expect_sig(4, 0, "R12 pu after second reset");
      expect_sig(1, 0, "R12 cfg after second reset");

      idle(3);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule